// File: doc/BRIEF.md
# Serial Tone-Control Configuration Port

This block is the programming front end of a tone encoder/decoder. A host loads an 8-bit control word one bit at a time. Each bit is taken on a rising edge of a serial clock, and only while an active-low serial enable is asserted. The word carries a 6-bit tone selector, a receive/transmit mode bit and one auxiliary control bit.

A bank of holding registers sits between the shift register and the outputs. A load/latch input controls it. While load/latch is high, the holding bank follows the shift register. While it is low, the bank keeps its value. The usual way to update is to shift all eight bits with load/latch low and then pulse load/latch 0-1-0.

All serial inputs are resynchronised to the system clock. Their idle level is logic 1, which stands in for pull-ups. The mode output is the latched mode bit ANDed with a dedicated mode pin. Holding that pin low forces transmit.

Top module: `tone_cfg_port`

## Requirements
- R1: After reset the shift register and holding bank give tone_code_o = 0 and aux_ctl_o = 0. They also give rx_mode_o = 1 (receive) while mode_pin_i is high.
- R2: Bits are captured on rising serial-clock edges. The first bit of a word becomes tone_code_o[5], the next ones fill tone_code_o[4] down to tone_code_o[0], the seventh is the mode bit and the eighth is aux_ctl_o.
- R3: Serial-clock edges that arrive while ser_en_ni is high leave the stored word unchanged.
- R4: When more than eight bits are clocked in, only the last eight are kept, in the mapping of R2.
- R5: While ld_lat_i is low, the outputs do not change, even when bits are being shifted.
- R6: While ld_lat_i is high, the outputs follow the shift register after each captured bit.
- R7: A 0-1-0 pulse on ld_lat_i after a word has been shifted presents that word on the outputs.
- R8: rx_mode_o is 1 (receive) only when both the latched mode bit and mode_pin_i are 1. mode_pin_i low forces 0 (transmit).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ser_en_ni | input | 1 | Serial shift enable, active low, idles high |
| ser_dat_i | input | 1 | Serial data, idles high |
| ser_clk_i | input | 1 | Serial clock, data taken on its rising edge, idles high |
| ld_lat_i | input | 1 | Holding bank control: 1 transparent, 0 hold |
| mode_pin_i | input | 1 | Dedicated mode pin, 1 receive, 0 forces transmit |
| tone_code_o | output | 6 | Latched tone selector |
| rx_mode_o | output | 1 | Mode output, 1 receive, 0 transmit |
| aux_ctl_o | output | 1 | Latched auxiliary control bit |

## Verification
The first directed word is an asymmetric bit pattern, so a reversed or shifted field mapping shows up right away. An all-enabled-high burst and an 11-bit overrun tell a missing enable gate apart from a wrong history window. Shifting with the latch held low, and then again with it transparent, separates hold behaviour from follow behaviour. Random words of 6 to 10 bits, with occasional disabled bits and random mode-pin levels, mix all of these against a bench model of the register and holding bank.

// File: rtl/tone_cfg_pkg.sv
package tone_cfg_pkg;
  localparam int unsigned TONE_W = 6;
  localparam int unsigned WORD_W = TONE_W + 2;

  // field order matches shift order: first bit in ends up in the msb
  typedef struct packed {
    logic [TONE_W-1:0] tone;
    logic              mode;
    logic              aux;
  } cfg_word_t;

  // reset: tone and aux clear, mode defaults to receive
  localparam logic [WORD_W-1:0] CFG_RST = {{TONE_W{1'b0}}, 1'b1, 1'b0};
endpackage

// File: rtl/in_sync.sv
module in_sync #(
  parameter int unsigned WIDTH   = 4,
  parameter int unsigned STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) pipe_q[i] <= RST_VAL;
    end else begin
      pipe_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) pipe_q[i] <= pipe_q[i-1];
    end
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/cfg_shift.sv
module cfg_shift #(
  parameter int unsigned WIDTH = 8,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             shift_i,
  input  logic             din_i,
  output logic [WIDTH-1:0] word_o
);
  logic [WIDTH-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= RST_VAL;
    else if (shift_i) sr_q <= {sr_q[WIDTH-2:0], din_i};
  end

  assign word_o = sr_q;

  a_r3_idle_keeps_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_i |=> $stable(sr_q));
  a_r2_bit_enters_lsb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |=> (sr_q[0] == $past(din_i)) && (sr_q[WIDTH-1:1] == $past(sr_q[WIDTH-2:0])));
endmodule

// File: rtl/hold_bank.sv
module hold_bank #(
  parameter int unsigned WIDTH = 8,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] lat_q;

  // level-controlled: refreshed every cycle load is high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     lat_q <= RST_VAL;
    else if (load_i) lat_q <= d_i;
  end

  assign q_o = lat_q;

  a_r5_hold_when_closed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(lat_q));
  a_r6_follow_when_open: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> lat_q == $past(d_i));
endmodule

// File: rtl/tone_cfg_port.sv
module tone_cfg_port
  import tone_cfg_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ser_en_ni,
  input  logic              ser_dat_i,
  input  logic              ser_clk_i,
  input  logic              ld_lat_i,
  input  logic              mode_pin_i,
  output logic [TONE_W-1:0] tone_code_o,
  output logic              rx_mode_o,
  output logic              aux_ctl_o
);
  localparam int unsigned N_SYNC = 4;

  logic [N_SYNC-1:0] raw_in, syn_in;
  logic s_clk, s_dat, s_en_n, s_ld;
  logic sclk_prev_q, sclk_rise, shift_en;
  logic [WORD_W-1:0] sr_word, lat_word;
  cfg_word_t cfg;

  assign raw_in = {ser_clk_i, ser_dat_i, ser_en_ni, ld_lat_i};

  // idle level 1 in reset, mirroring undriven pins
  in_sync #(.WIDTH(N_SYNC), .STAGES(SYNC_STAGES), .RST_VAL({N_SYNC{1'b1}})) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_in),
    .q_o   (syn_in)
  );

  assign {s_clk, s_dat, s_en_n, s_ld} = syn_in;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_prev_q <= 1'b1;
    else         sclk_prev_q <= s_clk;
  end

  assign sclk_rise = s_clk & ~sclk_prev_q;
  assign shift_en  = sclk_rise & ~s_en_n;

  cfg_shift #(.WIDTH(WORD_W), .RST_VAL(CFG_RST)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .shift_i(shift_en),
    .din_i  (s_dat),
    .word_o (sr_word)
  );

  hold_bank #(.WIDTH(WORD_W), .RST_VAL(CFG_RST)) u_hold (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(s_ld),
    .d_i   (sr_word),
    .q_o   (lat_word)
  );

  assign cfg         = cfg_word_t'(lat_word);
  assign tone_code_o = cfg.tone;
  assign aux_ctl_o   = cfg.aux;
  assign rx_mode_o   = cfg.mode & mode_pin_i;

  a_r2_single_edge_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_rise |=> !sclk_rise);
  a_r3_disabled_no_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_en_n |=> $stable(sr_word));
  a_r5_outputs_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !s_ld |=> $stable({tone_code_o, aux_ctl_o}));
  a_r8_pin_forces_tx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_pin_i |-> !rx_mode_o);
endmodule

// File: tb/sim_tone_cfg_port.sv
module sim_tone_cfg_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_n = 1'b1, dat = 1'b1, sclk = 1'b1, ld = 1'b1, pin = 1'b1;
  logic [5:0] tone;
  logic rx_mode, aux;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [7:0] m_sr, m_lat;

  always #2.5 clk = ~clk;

  tone_cfg_port u0 (
    .clk_i(clk), .rst_ni(rst_n), .ser_en_ni(en_n), .ser_dat_i(dat),
    .ser_clk_i(sclk), .ld_lat_i(ld), .mode_pin_i(pin),
    .tone_code_o(tone), .rx_mode_o(rx_mode), .aux_ctl_o(aux)
  );

  function automatic logic [7:0] exp_out(logic [7:0] lat, logic p);
    return {lat[7:2], lat[1] & p, lat[0]};
  endfunction

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req);
    logic [7:0] got, exp;
    got = {tone, rx_mode, aux};
    exp = exp_out(m_lat, pin);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got tone=%b mode=%b aux=%b, expected tone=%b mode=%b aux=%b",
               req, got[7:2], got[1], got[0], exp[7:2], exp[1], exp[0]);
    end
  endtask

  task automatic shift_bit(logic b, logic en);
    en_n = en;
    dat  = b;
    wait_cyc(3);
    sclk = 1'b1;
    wait_cyc(4);
    sclk = 1'b0;
    wait_cyc(3);
    if (!en) m_sr = {m_sr[6:0], b};
    if (ld) m_lat = m_sr;
  endtask

  task automatic shift_word(logic [7:0] w);
    for (int i = 7; i >= 0; i--) shift_bit(w[i], 1'b0);
  endtask

  task automatic pulse_load();
    ld = 1'b1;
    wait_cyc(5);
    ld = 1'b0;
    wait_cyc(5);
    m_lat = m_sr;
  endtask

  initial begin
    #500000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    m_sr  = 8'b0000_0010;
    m_lat = 8'b0000_0010;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(6);
    check("R1 reset state");
    pin = 1'b0;
    wait_cyc(1);
    check("R1 reset state with pin low");
    pin = 1'b1;

    // R5/R7 directed asymmetric word with latch closed
    ld = 1'b0;
    sclk = 1'b0;
    wait_cyc(6);
    shift_word(8'b1011_0010);
    check("R5 outputs frozen while shifting");
    pulse_load();
    check("R7 load pulse presents word");
    check("R2 bit order mapping");

    // R3 enable high: edges ignored
    for (int i = 0; i < 8; i++) shift_bit(1'(i % 2), 1'b1);
    en_n = 1'b1;
    pulse_load();
    check("R3 disabled edges ignored");

    // R4 overrun: 11 bits, last eight kept
    shift_word(8'b1111_0000);
    shift_bit(1'b0, 1'b0);
    shift_bit(1'b1, 1'b1 ^ 1'b1);
    shift_bit(1'b1, 1'b0);
    pulse_load();
    check("R4 only last eight kept");

    // R6 transparent: follow each bit
    ld = 1'b1;
    wait_cyc(5);
    m_lat = m_sr;
    for (int i = 0; i < 8; i++) begin
      shift_bit(1'((8'b0110_1101 >> (7 - i)) & 1), 1'b0);
      check("R6 transparent follows shift");
    end
    ld = 1'b0;
    wait_cyc(5);

    // R8 mode pin override
    shift_word(8'b0000_0010);
    pulse_load();
    check("R8 mode bit 1 pin high receive");
    pin = 1'b0;
    wait_cyc(1);
    check("R8 pin low forces transmit");
    pin = 1'b1;
    shift_word(8'b0000_0000);
    pulse_load();
    check("R8 mode bit 0 pin high transmit");

    // random mix
    for (int k = 0; k < 24; k++) begin
      int len;
      len = 6 + int'($urandom_range(4));
      for (int i = 0; i < len; i++)
        shift_bit(1'($urandom_range(1)), ($urandom_range(7) == 0));
      en_n = 1'b1;
      pin = 1'($urandom_range(3) != 0);
      wait_cyc(2);
      check("R5 random hold before load");
      pulse_load();
      check("R2 random word after load");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule